// File: doc/BRIEF.md
# Multiplexed Bus Demultiplexer and Strobe Decoder

This block sits between an 8-bit processor whose low address byte and data share one set of lines and the separate memory and I/O devices behind it. When the address-latch-enable pulse is high, the block captures the shared lines. When the pulse falls, it holds that byte. It joins the held byte with the dedicated high address lines to form a 16-bit address. For I/O cycles it also presents the held byte alone as an 8-bit port number.

A small state machine turns the memory/IO select and the active-low read and write strobes into four separate enables: memory read, memory write, I/O read and I/O write. It ignores the strobes during the address phase. It refuses a cycle in which read and write are both asserted. During a decoded read it turns on its driver toward the processor. It also provides an active-low chip select for a memory region whose top address nibble equals a base value set at an input.

The design runs on one clock. Every decoded output and the held low byte reflect the inputs sampled at the previous rising edge. The assembled address, the port number, the chip select and the returned data follow the high address lines and the read data within the same cycle.

The state machine has eight states:
- ST_IDLE: after reset.
- ST_ADDR: address phase.
- ST_HOLD: address held, no strobe.
- ST_MEM_RD, ST_MEM_WR, ST_IO_RD and ST_IO_WR: one state per decoded transfer.
- ST_FAULT: conflicting strobes.

The transitions are evaluated in priority order at each edge:
1. From any state, a high enable moves to ST_ADDR.
2. Otherwise, both strobes low moves to ST_FAULT.
3. Otherwise, read low moves to ST_IO_RD when the select is 1 and to ST_MEM_RD when it is 0.
4. Otherwise, write low moves to ST_IO_WR or ST_MEM_WR in the same way.
5. Otherwise, with no strobe, ST_IDLE stays in ST_IDLE and every other state moves to ST_HOLD.

Top module: `bus_demux_strobe`

## Requirements
- R1: While reset is asserted, and until the first edge after it is released, all of the following hold: the four enables are 0, the error flag is 0, the driver enable is 0, the chip select is 1 and the held low byte is 00H.
- R2: At an edge where the latch enable is 1, the held low byte takes the value on the shared lines. At an edge where it is 0, the held byte keeps its value, whatever is then on the shared lines.
- R3: The address output is {high address lines, held low byte}. For example, high lines 20H and held byte 05H give 2005H. The port number output equals the held low byte.
- R4: Strobes are active low, and the select is 0 for memory and 1 for I/O. After an edge where the latch enable is 0 and exactly one strobe is 0, exactly one enable is raised: select 0 with read 0 gives the memory read enable; select 0 with write 0 gives memory write; select 1 with read 0 gives I/O read; select 1 with write 0 gives I/O write.
- R5: After an edge where the latch enable is 1, all four enables are 0, whatever the strobes and the select are.
- R6: After an edge where the latch enable is 0 and both strobes are 0, the error flag is 1 and all four enables are 0. Otherwise the error flag is 0.
- R7: The driver enable is 1 exactly when the memory read or the I/O read enable is 1. While it is 1, the driven data equals the read data input. While it is 0, the driven data is 00H.
- R8: The chip select is 0 exactly when the memory read or memory write enable is 1 and bits 7..4 of the high address lines equal the 4-bit base input. Otherwise it is 1.
- R9: At no time are two of the four enables 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ale | input | 1 | Address latch enable, high during the address phase |
| ad_in | input | 8 | Shared address/data lines as seen by the block |
| a_hi | input | 8 | Dedicated high address byte |
| io_m | input | 1 | Select: 0 memory, 1 I/O |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_data | input | 8 | Data returned by the selected device |
| cs_base | input | 4 | Base nibble for the chip-select region |
| addr | output | 16 | Assembled address |
| port_addr | output | 8 | I/O port number (held low byte) |
| mem_rd_en | output | 1 | Memory read enable |
| mem_wr_en | output | 1 | Memory write enable |
| io_rd_en | output | 1 | I/O read enable |
| io_wr_en | output | 1 | I/O write enable |
| bus_err | output | 1 | Read and write requested together |
| ad_oe | output | 1 | Driver enable toward the shared lines (0 means high impedance) |
| ad_out | output | 8 | Data driven onto the shared lines |
| cs_n | output | 1 | Chip select, active low |

## Verification
A wrong state register shows up one edge after the offending inputs. It appears as a wrong or extra enable, a missing error flag, or a driver or chip select active in a write or address cycle. Every cycle of the random stream compares all of these against a model, so the first bad cycle is caught. A fault in the held byte shows on the address and port outputs in the cycle after the edge. Directed runs keep the latch enable low while the shared lines change, so a latch that does not hold its value differs from the model right away.

// File: rtl/busdmx_pkg.sv
package busdmx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HOLD,
        ST_MEM_RD,
        ST_MEM_WR,
        ST_IO_RD,
        ST_IO_WR,
        ST_FAULT
    } bus_state_t;
endpackage

// File: rtl/busdmx_lo_latch.sv
module busdmx_lo_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ale,
    input  logic [W-1:0] ad_in,
    output logic [W-1:0] lo_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (ale) begin
            lo_q <= ad_in;
        end
    end
endmodule

// File: rtl/busdmx_fsm.sv
module busdmx_fsm
    import busdmx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ale,
    input  logic io_m,
    input  logic rd_n,
    input  logic wr_n,
    output logic mem_rd,
    output logic mem_wr,
    output logic io_rd,
    output logic io_wr,
    output logic fault,
    output logic mem_cycle
);
    bus_state_t state, state_nx;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions, in priority order: address phase, conflict, read, write, idle/hold.
    always_comb begin
        if (ale) begin
            state_nx = ST_ADDR;
        end else if (!rd_n && !wr_n) begin
            state_nx = ST_FAULT;
        end else if (!rd_n) begin
            state_nx = io_m ? ST_IO_RD : ST_MEM_RD;
        end else if (!wr_n) begin
            state_nx = io_m ? ST_IO_WR : ST_MEM_WR;
        end else if (state == ST_IDLE) begin
            state_nx = ST_IDLE;
        end else begin
            state_nx = ST_HOLD;
        end
    end

    // Moore outputs.
    always_comb begin
        mem_rd = 1'b0;
        mem_wr = 1'b0;
        io_rd  = 1'b0;
        io_wr  = 1'b0;
        fault  = 1'b0;
        unique case (state)
            ST_IDLE, ST_ADDR, ST_HOLD: ;
            ST_MEM_RD: mem_rd = 1'b1;
            ST_MEM_WR: mem_wr = 1'b1;
            ST_IO_RD:  io_rd  = 1'b1;
            ST_IO_WR:  io_wr  = 1'b1;
            ST_FAULT:  fault  = 1'b1;
            default: ;
        endcase
        mem_cycle = mem_rd | mem_wr;
    end
endmodule

// File: rtl/busdmx_cs_dec.sv
module busdmx_cs_dec #(
    parameter int HI_W  = 8,
    parameter int SEL_W = 4
) (
    input  logic [HI_W-1:0]  a_hi,
    input  logic [SEL_W-1:0] base,
    input  logic             mem_cycle,
    output logic             cs_n
);
    logic hit;

    generate
        if (SEL_W == 0) begin : g_nosel
            assign hit = 1'b1;
        end else begin : g_sel
            assign hit = (a_hi[HI_W-1 -: SEL_W] == base);
        end
    endgenerate

    assign cs_n = ~(mem_cycle & hit);
endmodule

// File: rtl/bus_demux_strobe.sv
module bus_demux_strobe #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int SEL_W  = 4,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic [DATA_W-1:0] ad_in,
    input  logic [HI_W-1:0]   a_hi,
    input  logic              io_m,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [SEL_W-1:0]  cs_base,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] port_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic              io_rd_en,
    output logic              io_wr_en,
    output logic              bus_err,
    output logic              ad_oe,
    output logic [DATA_W-1:0] ad_out,
    output logic              cs_n
);
    logic [DATA_W-1:0] lo_q;
    logic              mem_cycle;

    busdmx_lo_latch #(.W(DATA_W)) u_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .ale   (ale),
        .ad_in (ad_in),
        .lo_q  (lo_q)
    );

    busdmx_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ale       (ale),
        .io_m      (io_m),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .mem_rd    (mem_rd_en),
        .mem_wr    (mem_wr_en),
        .io_rd     (io_rd_en),
        .io_wr     (io_wr_en),
        .fault     (bus_err),
        .mem_cycle (mem_cycle)
    );

    busdmx_cs_dec #(.HI_W(HI_W), .SEL_W(SEL_W)) u_cs (
        .a_hi      (a_hi),
        .base      (cs_base),
        .mem_cycle (mem_cycle),
        .cs_n      (cs_n)
    );

    assign addr      = {a_hi, lo_q};
    assign port_addr = lo_q;
    assign ad_oe     = mem_rd_en | io_rd_en;
    assign ad_out    = ad_oe ? rd_data : '0;
endmodule

// File: rtl/bus_demux_strobe_chk.sv
module bus_demux_strobe_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ale,
    input logic [DATA_W-1:0] port_addr,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic              io_rd_en,
    input logic              io_wr_en,
    input logic              bus_err,
    input logic              ad_oe,
    input logic              cs_n
);
    // R9
    one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_en, mem_wr_en, io_rd_en, io_wr_en}));

    // R6
    err_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> !(mem_rd_en || mem_wr_en || io_rd_en || io_wr_en));

    // R5
    addr_phase_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ale) |-> !(mem_rd_en || mem_wr_en || io_rd_en || io_wr_en || bus_err));

    // R2
    lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ale) |-> $stable(port_addr));

    // R7
    drive_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (mem_rd_en || io_rd_en));

    // R8
    cs_mem_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> (mem_rd_en || mem_wr_en));
endmodule

bind bus_demux_strobe bus_demux_strobe_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ale       (ale),
    .port_addr (port_addr),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .io_rd_en  (io_rd_en),
    .io_wr_en  (io_wr_en),
    .bus_err   (bus_err),
    .ad_oe     (ad_oe),
    .cs_n      (cs_n)
);

// File: tb/tb_bus_demux_strobe.sv
`timescale 1ns/1ps
module tb_bus_demux_strobe;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ale = 1'b0;
    logic [7:0]  ad_in = 8'h00;
    logic [7:0]  a_hi = 8'h00;
    logic        io_m = 1'b0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [7:0]  rd_data = 8'h00;
    logic [3:0]  cs_base = 4'h0;
    logic [15:0] addr;
    logic [7:0]  port_addr;
    logic        mem_rd_en, mem_wr_en, io_rd_en, io_wr_en, bus_err, ad_oe, cs_n;
    logic [7:0]  ad_out;

    int tests = 0;
    int fails = 0;
    logic [7:0] exp_lo = 8'h00;
    bit done = 0;

    always #4 clk = ~clk;

    bus_demux_strobe dut (
        .clk(clk), .rst_n(rst_n), .ale(ale), .ad_in(ad_in), .a_hi(a_hi),
        .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n), .rd_data(rd_data), .cs_base(cs_base),
        .addr(addr), .port_addr(port_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .io_rd_en(io_rd_en), .io_wr_en(io_wr_en), .bus_err(bus_err), .ad_oe(ad_oe),
        .ad_out(ad_out), .cs_n(cs_n)
    );

    // 0 none, 1 mem rd, 2 mem wr, 3 io rd, 4 io wr, 5 fault
    function automatic int exp_code(logic a, logic sel, logic r, logic w);
        if (a) return 0;
        if (!r && !w) return 5;
        if (!r) return sel ? 3 : 1;
        if (!w) return sel ? 4 : 2;
        return 0;
    endfunction

    task automatic chk(string tag, int got, int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic check_all(string tag, int code);
        logic rd;
        rd = (code == 1) || (code == 3);
        chk({tag, " R4 mem_rd"}, int'(mem_rd_en), int'(code == 1));
        chk({tag, " R4 mem_wr"}, int'(mem_wr_en), int'(code == 2));
        chk({tag, " R4 io_rd"},  int'(io_rd_en),  int'(code == 3));
        chk({tag, " R4 io_wr"},  int'(io_wr_en),  int'(code == 4));
        chk({tag, " R6 err"},    int'(bus_err),   int'(code == 5));
        chk({tag, " R7 oe"},     int'(ad_oe),     int'(rd));
        chk({tag, " R7 data"},   int'(ad_out),    rd ? int'(rd_data) : 0);
        chk({tag, " R8 cs_n"},   int'(cs_n),
            int'(!(((code == 1) || (code == 2)) && (a_hi[7:4] == cs_base))));
        chk({tag, " R2 lo"},     int'(port_addr), int'(exp_lo));
        chk({tag, " R3 addr"},   int'(addr),      int'({a_hi, exp_lo}));
        chk({tag, " R9 onehot"},
            int'(mem_rd_en) + int'(mem_wr_en) + int'(io_rd_en) + int'(io_wr_en) <= 1 ? 1 : 0, 1);
    endtask

    // Drive at negedge, check 2 ns after the following rising edge.
    task automatic cyc(string tag, logic a, logic [7:0] ad, logic [7:0] hi,
                       logic sel, logic r, logic w, logic [7:0] rdd, logic [3:0] base);
        int code;
        @(negedge clk);
        ale = a; ad_in = ad; a_hi = hi; io_m = sel; rd_n = r; wr_n = w;
        rd_data = rdd; cs_base = base;
        code = exp_code(a, sel, r, w);
        if (a) exp_lo = ad;
        @(posedge clk);
        #2;
        check_all(tag, code);
    endtask

    initial begin
        #400000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h1234_5678;
        void'($urandom(seed));
        ad_in = 8'hA5;
        ale = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state, even with ale high and lines busy
        chk("R1 mem_rd", int'(mem_rd_en), 0);
        chk("R1 io_wr",  int'(io_wr_en), 0);
        chk("R1 err",    int'(bus_err), 0);
        chk("R1 oe",     int'(ad_oe), 0);
        chk("R1 cs_n",   int'(cs_n), 1);
        chk("R1 lo",     int'(port_addr), 0);
        @(negedge clk);
        ale = 1'b0;
        rst_n = 1'b1;

        // R3 example: 20H high, 05H low -> 2005H, then memory read
        cyc("R3 ale",   1, 8'h05, 8'h20, 0, 1, 1, 8'h4F, 4'h2);
        cyc("R3 hold",  0, 8'hEE, 8'h20, 0, 1, 1, 8'h4F, 4'h2);
        chk("R3 2005", int'(addr), 16'h2005);
        cyc("R4 mrd",   0, 8'h4F, 8'h20, 0, 0, 1, 8'h4F, 4'h2);
        cyc("R4 mwr",   0, 8'h11, 8'h20, 0, 1, 0, 8'h4F, 4'h2);
        cyc("R4 ird",   0, 8'h22, 8'h20, 1, 0, 1, 8'h9C, 4'h2);
        cyc("R4 iwr",   0, 8'h33, 8'h20, 1, 1, 0, 8'h9C, 4'h2);
        // R5 strobes ignored in address phase
        cyc("R5 ale rd", 1, 8'h77, 8'h80, 0, 0, 1, 8'h12, 4'h8);
        cyc("R5 ale ww", 1, 8'h78, 8'h80, 1, 0, 0, 8'h12, 4'h8);
        // R6 conflict
        cyc("R6 both",  0, 8'h00, 8'h80, 0, 0, 0, 8'h12, 4'h8);
        cyc("R6 rel",   0, 8'hFF, 8'h80, 0, 1, 1, 8'h12, 4'h8);
        // R8 chip select hit vs miss
        cyc("R8 hit",   0, 8'h01, 8'h8F, 0, 1, 0, 8'h00, 4'h8);
        cyc("R8 miss",  0, 8'h01, 8'h7F, 0, 1, 0, 8'h00, 4'h8);
        cyc("R8 io",    0, 8'h01, 8'h8F, 1, 0, 1, 8'h5A, 4'h8);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            cyc("rnd", (rv[2:0] == 3'd0), rv[15:8], {rv[17:16], rv[21:18], 2'b00},
                rv[22], rv[23] | rv[24], rv[25] | rv[26], rv[31:24], {rv[17:16], rv[19:18]});
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule